// File: doc/BRIEF.md
# Deferred-Fault Register File with Per-Entry Poison Tracking

This block is a general-purpose register file in which every entry carries one extra status bit that marks its contents as invalid because of an exception that was deferred. An issuing pipeline presents one instruction per cycle. Each instruction has a flag that says whether it was hoisted speculatively. It also carries two source indices, each with a use flag, an optional destination write, and an exception report with its kind.

A speculative instruction that hits a terminating exception does not trap. Its destination is marked poisoned, and the mark spreads to any later speculative result computed from it. The trap is raised only when a non-speculative instruction consumes a poisoned value. Resumable exceptions are handed straight back to the handler, whether or not the instruction is speculative. The register file reports the faulting register index with each fault.

Top module: `deferred_fault_regfile`

## Requirements
- R1: After a synchronous active-low reset, every entry reads zero data and a clear poison flag, and `fault_vld` and `resume_req` are low.
- R2: Entry 0 always reads zero data and a clear poison flag. Writes, poison marks and speculative exceptions aimed at it have no visible effect.
- R3: A normal instruction with `dst_we`=1, no exception and no poisoned used source writes `dst_wdata` to the destination and clears the destination's poison flag on the next clock edge.
- R4: A speculative instruction with `dst_we`=1, no exception and no poisoned used source writes its data and clears the destination's poison flag, exactly as a normal instruction does.
- R5: A speculative instruction that reports a terminating exception (`exc_vld`=1, `exc_term`=1) with `dst_we`=1 sets the destination's poison flag. The destination data is left unchanged, and no fault or resume request is raised.
- R6: A speculative instruction with no exception that reads a used, poisoned source and has `dst_we`=1 sets the destination's poison flag, leaves its data unchanged and raises no fault.
- R7: A normal instruction that reads a used, poisoned source raises `fault_vld` one cycle later with `fault_cause`=0. `fault_idx` is source A if A is used and poisoned, otherwise source B. The destination write is suppressed. This check takes priority over any exception reported by the same instruction.
- R8: The poison flag of a source whose use flag is 0 has no effect: no fault and no propagation.
- R9: A resumable exception (`exc_vld`=1, `exc_term`=0) raises `resume_req` one cycle later for speculative and normal instructions alike. It suppresses the destination write and leaves the poison flags unchanged.
- R10: A normal instruction that reports a terminating exception raises `fault_vld` one cycle later with `fault_cause`=1 and `fault_idx` equal to its destination index. Its write is suppressed.
- R11: `fault_vld` and `resume_req` are single-cycle pulses that never occur together, and stay low in any cycle that follows one with `issue_vld`=0.
- R12: The read ports are combinational and show the contents and poison flags as they were before the current cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_vld | input | 1 | An instruction is presented this cycle |
| issue_spec | input | 1 | 1 = speculative instruction, 0 = normal |
| src_a_idx | input | IDXW | Source A register index (also read port A) |
| src_a_use | input | 1 | Instruction consumes source A |
| src_b_idx | input | IDXW | Source B register index (also read port B) |
| src_b_use | input | 1 | Instruction consumes source B |
| dst_idx | input | IDXW | Destination register index |
| dst_we | input | 1 | Instruction writes its destination |
| dst_wdata | input | DW | Result data |
| exc_vld | input | 1 | Instruction reports an exception |
| exc_term | input | 1 | 1 = terminating exception, 0 = resumable |
| rd_a_data | output | DW | Data of entry `src_a_idx` |
| rd_b_data | output | DW | Data of entry `src_b_idx` |
| rd_a_poison | output | 1 | Poison flag of entry `src_a_idx` |
| rd_b_poison | output | 1 | Poison flag of entry `src_b_idx` |
| fault_vld | output | 1 | Fault pulse for the previous instruction |
| fault_cause | output | 1 | 0 = poisoned source consumed, 1 = terminating exception on a normal instruction |
| fault_idx | output | IDXW | Register index tied to the fault |
| resume_req | output | 1 | Resumable exception to be handled now |

## Verification
The bench targets the places where the precedence rules decide the outcome. A normal instruction that both reads poison and reports an exception must fault on the poison; a design that checked exceptions first would emit a resume request instead. When both sources are poisoned, source A must be reported; a design with the wrong priority would name the wrong register. An unused poisoned source must stay inert; a design that ignored the use flag would trap spuriously or spread poison. Entry 0 is targeted with writes and terminating speculative exceptions, and a clean write over a poisoned entry must revive it; a design that left the flag set would trap on valid data later. Long random streams cover the interleavings between these cases.

// File: rtl/dfr_pkg.sv
// Shared types for the deferred-fault register file.
package dfr_pkg;
    // Reason reported alongside a fault pulse.
    typedef enum logic {
        CAUSE_POISON_USE = 1'b0,
        CAUSE_TERM_EXC   = 1'b1
    } fault_cause_e;

    // Outcome selected for one issued instruction.
    typedef enum logic [2:0] {
        ACT_NONE   = 3'd0,
        ACT_WRITE  = 3'd1,
        ACT_POISON = 3'd2,
        ACT_FAULT  = 3'd3,
        ACT_RESUME = 3'd4
    } issue_act_e;
endpackage

// File: rtl/dfr_data_bank.sv
// Data storage for the register file.
// Provides one write port and NRD combinational read ports.
// Assumes index 0 is a constant-zero entry: writes to it are dropped.
module dfr_data_bank #(
    parameter int NREGS = 16,
    parameter int DW    = 32,
    parameter int NRD   = 2,
    localparam int IDXW = $clog2(NREGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [IDXW-1:0]           widx,
    input  logic [DW-1:0]             wdata,
    input  logic [NRD-1:0][IDXW-1:0]  rd_idx,
    output logic [NRD-1:0][DW-1:0]    rd_data
);
    logic [NREGS-1:0][DW-1:0] entry_q;

    // Update storage: clear on reset, otherwise write one nonzero entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q <= '0;
        end else if (we && (widx != '0)) begin
            entry_q[widx] <= wdata;
        end
    end

    // One read mux per port; entry 0 always reads zero.
    for (genvar r = 0; r < NRD; r++) begin : g_rd
        always_comb begin
            rd_data[r] = (rd_idx[r] == '0) ? '0 : entry_q[rd_idx[r]];
        end
    end
endmodule

// File: rtl/dfr_poison_track.sv
// One poison flag per register entry.
// Assumes set and clear are never requested in the same cycle; entry 0 is never marked.
module dfr_poison_track #(
    parameter int NREGS = 16,
    parameter int NRD   = 2,
    localparam int IDXW = $clog2(NREGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      set_en,
    input  logic                      clr_en,
    input  logic [IDXW-1:0]           idx,
    input  logic [NRD-1:0][IDXW-1:0]  rd_idx,
    output logic [NRD-1:0]            rd_psn
);
    logic [NREGS-1:0] psn_q;

    // Maintain flags: reset clears all, set or clear a nonzero entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psn_q <= '0;
        end else if (idx != '0) begin
            if (set_en) begin
                psn_q[idx] <= 1'b1;
            end else if (clr_en) begin
                psn_q[idx] <= 1'b0;
            end
        end
    end

    // One flag lookup per read port.
    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_psn[r] = psn_q[rd_idx[r]];
    end

    // R5 / R6
    poison_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && idx != '0) |=> psn_q[$past(idx)]);

    // R3
    poison_clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en && idx != '0) |=> !psn_q[$past(idx)]);
endmodule

// File: rtl/dfr_issue_ctrl.sv
// Decides what one issued instruction does to the register file.
// It writes, poisons its destination, faults, requests a resume, or does nothing.
// Registers the fault and resume reports.
// Assumes the source poison flags come from the poison tracker in the same cycle.
module dfr_issue_ctrl
    import dfr_pkg::*;
#(
    parameter int NREGS = 16,
    localparam int IDXW = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_vld,
    input  logic             issue_spec,
    input  logic [IDXW-1:0]  src_a_idx,
    input  logic             src_a_use,
    input  logic             src_a_psn,
    input  logic [IDXW-1:0]  src_b_idx,
    input  logic             src_b_use,
    input  logic             src_b_psn,
    input  logic [IDXW-1:0]  dst_idx,
    input  logic             dst_we,
    input  logic             exc_vld,
    input  logic             exc_term,
    output logic             bank_we,
    output logic             psn_set,
    output logic             psn_clr,
    output logic             fault_vld,
    output fault_cause_e     fault_cause,
    output logic [IDXW-1:0]  fault_idx,
    output logic             resume_req
);
    issue_act_e      act;
    fault_cause_e    cause_d;
    logic [IDXW-1:0] fidx_d;
    logic            a_hit;
    logic            b_hit;

    // Select the outcome by precedence: poisoned use, resumable, terminating, propagation, write.
    always_comb begin
        a_hit   = src_a_use && src_a_psn;
        b_hit   = src_b_use && src_b_psn;
        act     = ACT_NONE;
        cause_d = CAUSE_POISON_USE;
        fidx_d  = a_hit ? src_a_idx : src_b_idx;
        if (issue_vld) begin
            if (!issue_spec && (a_hit || b_hit)) begin
                act = ACT_FAULT;
            end else if (exc_vld && !exc_term) begin
                act = ACT_RESUME;
            end else if (exc_vld && issue_spec) begin
                act = dst_we ? ACT_POISON : ACT_NONE;
            end else if (exc_vld) begin
                act     = ACT_FAULT;
                cause_d = CAUSE_TERM_EXC;
                fidx_d  = dst_idx;
            end else if (issue_spec && (a_hit || b_hit)) begin
                act = dst_we ? ACT_POISON : ACT_NONE;
            end else if (dst_we) begin
                act = ACT_WRITE;
            end
        end
    end

    assign bank_we = (act == ACT_WRITE);
    assign psn_clr = (act == ACT_WRITE);
    assign psn_set = (act == ACT_POISON);

    // Register the fault and resume reports for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_vld   <= 1'b0;
            fault_cause <= CAUSE_POISON_USE;
            fault_idx   <= '0;
            resume_req  <= 1'b0;
        end else begin
            fault_vld   <= (act == ACT_FAULT);
            fault_cause <= cause_d;
            fault_idx   <= fidx_d;
            resume_req  <= (act == ACT_RESUME);
        end
    end

    // R7 / R10
    fault_from_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_vld |-> $past(issue_vld && !issue_spec));

    // R7
    fault_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_vld |-> !$past(bank_we));

    // R9
    resume_from_resumable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_req |-> $past(issue_vld && exc_vld && !exc_term && !bank_we));

    // R11
    report_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_vld && resume_req));
endmodule

// File: rtl/deferred_fault_regfile.sv
// Register file with a poison flag per entry.
// Speculative terminating exceptions are deferred until a normal instruction consumes the result.
// Assumes one instruction per cycle.
// Read ports A and B follow the source indices whether or not an instruction issues.
module deferred_fault_regfile
    import dfr_pkg::*;
#(
    parameter int NREGS = 16,
    parameter int DW    = 32,
    localparam int IDXW = $clog2(NREGS),
    localparam int NRD  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_vld,
    input  logic             issue_spec,
    input  logic [IDXW-1:0]  src_a_idx,
    input  logic             src_a_use,
    input  logic [IDXW-1:0]  src_b_idx,
    input  logic             src_b_use,
    input  logic [IDXW-1:0]  dst_idx,
    input  logic             dst_we,
    input  logic [DW-1:0]    dst_wdata,
    input  logic             exc_vld,
    input  logic             exc_term,
    output logic [DW-1:0]    rd_a_data,
    output logic [DW-1:0]    rd_b_data,
    output logic             rd_a_poison,
    output logic             rd_b_poison,
    output logic             fault_vld,
    output logic             fault_cause,
    output logic [IDXW-1:0]  fault_idx,
    output logic             resume_req
);
    logic [NRD-1:0][IDXW-1:0] rd_idx;
    logic [NRD-1:0][DW-1:0]   rd_data;
    logic [NRD-1:0]           rd_psn;
    logic                     bank_we;
    logic                     psn_set;
    logic                     psn_clr;
    fault_cause_e             cause_e;

    assign rd_idx[0]   = src_a_idx;
    assign rd_idx[1]   = src_b_idx;
    assign rd_a_data   = rd_data[0];
    assign rd_b_data   = rd_data[1];
    assign rd_a_poison = rd_psn[0];
    assign rd_b_poison = rd_psn[1];
    assign fault_cause = cause_e;

    dfr_data_bank #(.NREGS(NREGS), .DW(DW), .NRD(NRD)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bank_we),
        .widx    (dst_idx),
        .wdata   (dst_wdata),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    dfr_poison_track #(.NREGS(NREGS), .NRD(NRD)) u_psn (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (psn_set),
        .clr_en (psn_clr),
        .idx    (dst_idx),
        .rd_idx (rd_idx),
        .rd_psn (rd_psn)
    );

    dfr_issue_ctrl #(.NREGS(NREGS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_vld   (issue_vld),
        .issue_spec  (issue_spec),
        .src_a_idx   (src_a_idx),
        .src_a_use   (src_a_use),
        .src_a_psn   (rd_psn[0]),
        .src_b_idx   (src_b_idx),
        .src_b_use   (src_b_use),
        .src_b_psn   (rd_psn[1]),
        .dst_idx     (dst_idx),
        .dst_we      (dst_we),
        .exc_vld     (exc_vld),
        .exc_term    (exc_term),
        .bank_we     (bank_we),
        .psn_set     (psn_set),
        .psn_clr     (psn_clr),
        .fault_vld   (fault_vld),
        .fault_cause (cause_e),
        .fault_idx   (fault_idx),
        .resume_req  (resume_req)
    );

    // R2
    zero_entry_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a_idx == '0) |-> (!rd_a_poison && rd_a_data == '0));

    // R11
    idle_no_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(issue_vld) |-> (!fault_vld && !resume_req));
endmodule

// File: tb/deferred_fault_regfile_tb_top.sv
`timescale 1ns/100ps
module deferred_fault_regfile_tb_top;
    localparam int NREGS = 16;
    localparam int DW    = 32;
    localparam int IDXW  = $clog2(NREGS);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            issue_vld = 0, issue_spec = 0, src_a_use = 0, src_b_use = 0;
    logic            dst_we = 0, exc_vld = 0, exc_term = 0;
    logic [IDXW-1:0] src_a_idx = '0, src_b_idx = '0, dst_idx = '0;
    logic [DW-1:0]   dst_wdata = '0;
    logic [DW-1:0]   rd_a_data, rd_b_data;
    logic            rd_a_poison, rd_b_poison, fault_vld, fault_cause, resume_req;
    logic [IDXW-1:0] fault_idx;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Behavioural reference state
    logic [DW-1:0] mdata [NREGS];
    bit            mpsn  [NREGS];

    always #2.5 clk = ~clk;

    deferred_fault_regfile #(.NREGS(NREGS), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .issue_spec(issue_spec),
        .src_a_idx(src_a_idx), .src_a_use(src_a_use), .src_b_idx(src_b_idx),
        .src_b_use(src_b_use), .dst_idx(dst_idx), .dst_we(dst_we),
        .dst_wdata(dst_wdata), .exc_vld(exc_vld), .exc_term(exc_term),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .rd_a_poison(rd_a_poison),
        .rd_b_poison(rd_b_poison), .fault_vld(fault_vld), .fault_cause(fault_cause),
        .fault_idx(fault_idx), .resume_req(resume_req)
    );

    task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One instruction slot: drive at negedge, check reads, model the edge, check reports.
    task automatic step(bit v, bit sp, int a, bit ua, int b, bit ub, int d, bit we,
                        logic [DW-1:0] wd, bit ev, bit et, string tag);
        bit ap, bp, e_fault, e_res, e_cause;
        int e_idx;
        @(negedge clk);
        issue_vld = v; issue_spec = sp; src_a_idx = IDXW'(a); src_a_use = ua;
        src_b_idx = IDXW'(b); src_b_use = ub; dst_idx = IDXW'(d); dst_we = we;
        dst_wdata = wd; exc_vld = ev; exc_term = et;
        #1;
        chk(tag, "rd_a_data",   rd_a_data,   mdata[a]);
        chk(tag, "rd_b_data",   rd_b_data,   mdata[b]);
        chk(tag, "rd_a_poison", DW'(rd_a_poison), DW'(mpsn[a]));
        chk(tag, "rd_b_poison", DW'(rd_b_poison), DW'(mpsn[b]));
        ap = ua && mpsn[a];
        bp = ub && mpsn[b];
        e_fault = 0; e_res = 0; e_cause = 0; e_idx = 0;
        @(posedge clk);
        #1;
        if (v) begin
            if (!sp && (ap || bp)) begin
                e_fault = 1; e_idx = ap ? a : b;
            end else if (ev && !et) begin
                e_res = 1;
            end else if (ev) begin
                if (sp) begin
                    if (we && d != 0) mpsn[d] = 1;
                end else begin
                    e_fault = 1; e_cause = 1; e_idx = d;
                end
            end else if (sp && (ap || bp)) begin
                if (we && d != 0) mpsn[d] = 1;
            end else if (we && d != 0) begin
                mdata[d] = wd; mpsn[d] = 0;
            end
        end
        chk(tag, "fault_vld",  DW'(fault_vld),  DW'(e_fault));
        chk(tag, "resume_req", DW'(resume_req), DW'(e_res));
        if (e_fault) begin
            chk(tag, "fault_cause", DW'(fault_cause), DW'(e_cause));
            chk(tag, "fault_idx",   DW'(fault_idx),   DW'(e_idx));
        end
    endtask

    // Read-only observation of two entries.
    task automatic peek(int a, int b, string tag);
        step(0, 0, a, 0, b, 0, 0, 0, '0, 0, 0, tag);
    endtask

    initial begin
        for (int i = 0; i < NREGS; i++) begin mdata[i] = '0; mpsn[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state of every entry and of the reports
        for (int i = 0; i < NREGS; i += 2) peek(i, i + 1, "R1");
        chk("R1", "fault_vld after reset", DW'(fault_vld), 0);

        // R3: normal write, then read back
        step(0, 0, 0, 0, 0, 0, 3, 1, 32'h0000_0033, 0, 0, "R3");
        step(1, 0, 0, 0, 0, 0, 3, 1, 32'h0000_0033, 0, 0, "R3");
        step(1, 0, 1, 1, 2, 1, 5, 1, 32'h0000_0055, 0, 0, "R3");
        peek(3, 5, "R3");
        // R2: writes to entry 0 are dropped
        step(1, 0, 3, 1, 0, 0, 0, 1, 32'hDEAD_BEEF, 0, 0, "R2");
        peek(0, 0, "R2");
        // R4: speculative clean write
        step(1, 1, 3, 1, 5, 1, 4, 1, 32'h0000_0044, 0, 0, "R4");
        peek(4, 3, "R4");
        // R5: speculative terminating exception poisons, keeps data
        step(1, 1, 3, 1, 0, 0, 5, 1, 32'h1111_1111, 1, 1, "R5");
        peek(5, 4, "R5");
        // R2: speculative terminating exception at entry 0
        step(1, 1, 3, 1, 0, 0, 0, 1, 32'h2222_2222, 1, 1, "R2");
        peek(0, 5, "R2");
        // R6: propagation through source A and through source B
        step(1, 1, 5, 1, 3, 1, 6, 1, 32'h6666_6666, 0, 0, "R6");
        step(1, 1, 3, 1, 6, 1, 7, 1, 32'h7777_7777, 0, 0, "R6");
        peek(6, 7, "R6");
        // R8: unused poisoned sources are inert
        step(1, 0, 5, 0, 6, 0, 8, 1, 32'h0000_0088, 0, 0, "R8");
        step(1, 1, 5, 0, 3, 1, 9, 1, 32'h0000_0099, 0, 0, "R8");
        peek(8, 9, "R8");
        // R7: normal consumer faults; A before B; priority over exceptions
        step(1, 0, 5, 1, 3, 1, 10, 1, 32'hAAAA_0000, 0, 0, "R7");
        step(1, 0, 3, 1, 6, 1, 10, 1, 32'hAAAA_0001, 0, 0, "R7");
        step(1, 0, 7, 1, 6, 1, 10, 1, 32'hAAAA_0002, 0, 0, "R7");
        step(1, 0, 5, 1, 0, 0, 10, 1, 32'hAAAA_0003, 1, 0, "R7");
        step(1, 0, 0, 0, 6, 1, 10, 1, 32'hAAAA_0004, 1, 1, "R7");
        peek(10, 6, "R7");
        // R3: clean normal write revives a poisoned entry
        step(1, 0, 3, 1, 4, 1, 5, 1, 32'h5555_0000, 0, 0, "R3");
        step(1, 0, 5, 1, 0, 0, 11, 1, 32'h0000_00BB, 0, 0, "R3");
        // R9: resumable exceptions, speculative and normal
        step(1, 1, 3, 1, 0, 0, 12, 1, 32'hCCCC_0000, 1, 0, "R9");
        step(1, 0, 3, 1, 0, 0, 12, 1, 32'hCCCC_0001, 1, 0, "R9");
        step(1, 1, 6, 1, 0, 0, 7, 1, 32'hCCCC_0002, 1, 0, "R9");
        peek(12, 7, "R9");
        // R10: normal terminating exception
        step(1, 0, 3, 1, 4, 1, 13, 1, 32'hDDDD_0000, 1, 1, "R10");
        step(1, 0, 3, 1, 4, 1, 0, 0, 32'hDDDD_0001, 1, 1, "R10");
        peek(13, 0, "R10");
        // R11: idle cycles with exception inputs toggling
        step(0, 0, 6, 1, 7, 1, 14, 1, 32'hEEEE_0000, 1, 1, "R11");
        step(0, 1, 6, 1, 7, 1, 14, 1, 32'hEEEE_0001, 1, 0, "R11");
        peek(14, 6, "R11");
        // R12: random stream checked against the model on every clock
        for (int n = 0; n < 600; n++) begin
            int r = $urandom_range(0, 9);
            step($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1,
                 $urandom_range(0, NREGS-1), $urandom_range(0, 1) == 1,
                 $urandom_range(0, NREGS-1), $urandom_range(0, 1) == 1,
                 $urandom_range(0, NREGS-1), $urandom_range(0, 3) != 0,
                 $urandom(), r < 3, r < 2, "R12");
        end
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL R11 watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule